// File: doc/BRIEF.md
# Active-Low Serial Link Transceiver

This block drives one two-wire serial link, a clock pin and a bidirectional data pin, for a host-side engine that builds frames and decides on retries elsewhere. Each command runs a single link operation. It can transmit a frame given as a word and a bit count, followed by echo-delay idle clocks. It can receive a response frame. It can clock idle periods, or run the break sequence that resets the far end. Data is active low on the wire: a logical 1 is a low pin level, in both directions.

Receiving first hunts for a start bit, and gives up after a fixed number of link clocks. It then reads a header, an optional data field whose length depends on the tag in the header, and a 4-bit check code. The result is reported as ok, timeout, check error or link dead. The block owns the direction of the data pad and the enable of an external level translator. It switches both to receive for the receive operation and back to drive for every other operation.

Top module: `alink_xcvr`

## Requirements
- R1: After reset, cmd_ready=1, op_done=0, lnk_clk=1, lnk_do=1, lnk_oe=1, lnk_trans=1, resp_status=0, resp_bits=0 and resp_word=0.
- R2: A command is taken on a rising clk edge where cmd_valid and cmd_ready are both 1. cmd_ready stays 0 until the operation ends, and cmd_valid is ignored while it is 0. op_done pulses for one cycle at the end of every operation, and cmd_ready is 1 in that same cycle. cmd_op encodes the operation: 0 send, 1 receive, 2 idle clocks, 3 break.
- R3: Each link period holds lnk_clk low for DIV clk cycles and then high for DIV cycles. Periods follow each other with no gap. An operation of P periods raises op_done 2*DIV*P cycles after the command is taken. lnk_do changes only together with a falling lnk_clk, and lnk_clk is high whenever the block is idle.
- R4: A send with tx_bits=N (1 to FRAME_W) drives one start period with lnk_do=0. It then drives N periods carrying the inverted bits tx_word[N-1] down to tx_word[0], in that order.
- R5: After the frame bits, a send adds echo_count periods with lnk_do=1, which may be none. A send with tx_bits=0 toggles no clock and ends with op_done in the cycle after it is taken.
- R6: An idle-clock command drives zero_count periods with lnk_do=1. When zero_count=0 it toggles no clock.
- R7: A break drives PRE_BRK periods high, then BRK_CLKS periods low, then echo_count periods high, then POST_BRK periods high.
- R8: lnk_oe and lnk_trans are always equal. They go to 0 when a receive is taken and stay 0 until the next send, idle-clock or break command is taken, which sets them to 1.
- R9: A receive samples lnk_di once per period, at the end of the low half, and inverts it to get the logical bit. If no logical 1 (start) appears within TIMEOUT_CLKS periods, the receive ends with resp_status=1 and resp_bits=0.
- R10: After the start bit, 4 header bits are read (2-bit id, then 2-bit tag). If the tag is 2'b00 and rx_bytes is nonzero, 8*rx_bytes data bits follow. Then 4 check bits are read. All bits after the start bit are shifted into resp_word, right-aligned with the first one received highest, and resp_bits gives their count.
- R11: The check register is 4 bits, polynomial x^4+x+1, shifted MSB-first. It starts at 0, takes one logical 1 for the start bit, and then takes every received bit, including the check bits. A zero remainder gives resp_status=0; a nonzero one gives resp_status=2.
- R12: When the remainder is nonzero and every received bit after the start bit was a logical 1 (pin held low), resp_status is 3 instead of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_op | input | 2 | Operation: 0 send, 1 receive, 2 idle clocks, 3 break |
| tx_word | input | FRAME_W | Frame to send, right-aligned |
| tx_bits | input | BITS_W | Number of frame bits to send |
| zero_count | input | CNT_W | Period count for idle clocking |
| echo_count | input | CNT_W | Echo-delay periods after a send and inside a break |
| rx_bytes | input | BYTES_W | Data bytes expected when the tag is 2'b00 |
| op_done | output | 1 | One-cycle pulse at the end of an operation |
| resp_status | output | 2 | 0 ok, 1 timeout, 2 check error, 3 link dead |
| resp_word | output | FRAME_W | Received bits after the start bit |
| resp_bits | output | BITS_W | Number of bits in resp_word |
| lnk_clk | output | 1 | Link clock pin |
| lnk_do | output | 1 | Data pin output value |
| lnk_oe | output | 1 | Data pin output enable |
| lnk_trans | output | 1 | Level translator drive enable |
| lnk_di | input | 1 | Data pin input value |

## Verification
Sends are run with a fixed pattern, random words of random length, zero echo delay and zero bits. This separates errors in bit order, inversion, start-bit insertion and echo counting. Receives are driven by a bench model of the far end with a random hunt delay, random ids, tags and byte counts, and deliberately flipped bits. A non-ack tag shows whether the data length follows the tag; a flipped bit must give a check error; a pin held low must give link dead, not a check error. A start bit in the very last hunt period and a line that never starts together bound the timeout count. Break and idle-clock runs, with and without echo periods, check the segment lengths and levels, and a command presented while busy must leave the pin trace untouched.

// File: rtl/alink_pkg.sv
package alink_pkg;

  typedef enum logic [1:0] {
    OP_SEND  = 2'd0,
    OP_RECV  = 2'd1,
    OP_ZEROS = 2'd2,
    OP_BREAK = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RS_OK      = 2'd0,
    RS_TIMEOUT = 2'd1,
    RS_CHECK   = 2'd2,
    RS_DEAD    = 2'd3
  } rsp_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TX,
    S_ZERO,
    S_BPRE,
    S_BLOW,
    S_BECHO,
    S_BPOST,
    S_HUNT,
    S_HDR,
    S_DATA,
    S_CHK
  } state_e;

  localparam logic [1:0] TAG_ACK  = 2'b00;
  localparam int         HDR_BITS = 4;
  localparam int         CHK_BITS = 4;

endpackage

// File: rtl/alink_tick.sv
module alink_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R3: the half-period counter never runs past its limit
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(DIV - 1));
endmodule

// File: rtl/alink_chk4.sv
module alink_chk4 #(
  parameter logic [3:0] POLY = 4'h3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       seed,
  input  logic       en,
  input  logic       d_i,
  output logic [3:0] rem_o
);
  function automatic logic [3:0] step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? POLY : 4'h0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       rem_o <= '0;
    else if (seed) rem_o <= step(4'h0, 1'b1);
    else if (en)   rem_o <= step(rem_o, d_i);
  end
endmodule

// File: rtl/alink_xcvr.sv
module alink_xcvr
  import alink_pkg::*;
#(
  parameter int FRAME_W      = 64,
  parameter int BITS_W       = $clog2(FRAME_W + 1),
  parameter int CNT_W        = 8,
  parameter int BYTES_W      = 3,
  parameter int DIV          = 4,
  parameter int TIMEOUT_CLKS = 40,
  parameter int PRE_BRK      = 4,
  parameter int BRK_CLKS     = 24,
  parameter int POST_BRK     = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [BITS_W-1:0]  tx_bits,
  input  logic [CNT_W-1:0]   zero_count,
  input  logic [CNT_W-1:0]   echo_count,
  input  logic [BYTES_W-1:0] rx_bytes,
  output logic               op_done,
  output logic [1:0]         resp_status,
  output logic [FRAME_W-1:0] resp_word,
  output logic [BITS_W-1:0]  resp_bits,
  output logic               lnk_clk,
  output logic               lnk_do,
  output logic               lnk_oe,
  output logic               lnk_trans,
  input  logic               lnk_di
);
  localparam int BYTE_MAX = (1 << BYTES_W) - 1;
  localparam int M1 = (TIMEOUT_CLKS > (1 << CNT_W)) ? TIMEOUT_CLKS : (1 << CNT_W);
  localparam int M2 = (M1 > 8 * BYTE_MAX) ? M1 : 8 * BYTE_MAX;
  localparam int M3 = (M2 > BRK_CLKS) ? M2 : BRK_CLKS;
  localparam int M4 = (M3 > PRE_BRK) ? M3 : PRE_BRK;
  localparam int MAXC = (M4 > POST_BRK) ? M4 : POST_BRK;
  localparam int RW = $clog2(MAXC + 1);
  localparam int LW = $clog2(DIV + 1) + 1;

  state_e               state;
  logic                 clk_q, do_q, oe_q, tr_q, low_q, samp_q, allones_q, done_q;
  logic [RW-1:0]        rem;
  logic [BITS_W-1:0]    idx;
  logic [FRAME_W-1:0]   word_q;
  logic [CNT_W-1:0]     echo_q;
  logic [BYTES_W-1:0]   bytes_q;
  logic [1:0]           rstat_q;
  logic [FRAME_W-1:0]   rword_q;
  logic [BITS_W-1:0]    rbits_q;
  logic                 busy, tick, rise, per_end, shift_st, seed;
  logic [3:0]           chk_rem;

  assign busy     = (state != S_IDLE);
  assign rise     = tick && low_q;
  assign per_end  = tick && !low_q;
  assign shift_st = (state == S_HDR) || (state == S_DATA) || (state == S_CHK);
  assign seed     = (state == S_IDLE) && cmd_valid && (op_e'(cmd_op) == OP_RECV);

  alink_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .tick(tick)
  );

  alink_chk4 u_chk (
    .clk  (clk),
    .rst  (rst),
    .seed (seed),
    .en   (rise && shift_st),
    .d_i  (~lnk_di),
    .rem_o(chk_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      clk_q     <= 1'b1;
      do_q      <= 1'b1;
      oe_q      <= 1'b1;
      tr_q      <= 1'b1;
      low_q     <= 1'b0;
      samp_q    <= 1'b0;
      allones_q <= 1'b0;
      done_q    <= 1'b0;
      rem       <= '0;
      idx       <= '0;
      word_q    <= '0;
      echo_q    <= '0;
      bytes_q   <= '0;
      rstat_q   <= RS_OK;
      rword_q   <= '0;
      rbits_q   <= '0;
    end else begin
      done_q <= 1'b0;
      // middle of the period: clock rises, input is sampled
      if (rise) begin
        clk_q  <= 1'b1;
        low_q  <= 1'b0;
        samp_q <= ~lnk_di;
        if (shift_st) begin
          rword_q   <= {rword_q[FRAME_W-2:0], ~lnk_di};
          rbits_q   <= rbits_q + 1'b1;
          allones_q <= allones_q & ~lnk_di;
        end
      end
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            case (op_e'(cmd_op))
              OP_SEND: begin
                oe_q <= 1'b1;
                tr_q <= 1'b1;
                if (tx_bits == '0) begin
                  done_q <= 1'b1;
                end else begin
                  state  <= S_TX;
                  word_q <= tx_word << (BITS_W'(FRAME_W) - tx_bits);
                  idx    <= tx_bits;
                  echo_q <= echo_count;
                  clk_q  <= 1'b0;
                  low_q  <= 1'b1;
                  do_q   <= 1'b0;
                end
              end
              OP_ZEROS: begin
                oe_q <= 1'b1;
                tr_q <= 1'b1;
                if (zero_count == '0) begin
                  done_q <= 1'b1;
                end else begin
                  state <= S_ZERO;
                  rem   <= RW'(zero_count);
                  clk_q <= 1'b0;
                  low_q <= 1'b1;
                  do_q  <= 1'b1;
                end
              end
              OP_BREAK: begin
                oe_q   <= 1'b1;
                tr_q   <= 1'b1;
                echo_q <= echo_count;
                state  <= S_BPRE;
                rem    <= RW'(PRE_BRK);
                clk_q  <= 1'b0;
                low_q  <= 1'b1;
                do_q   <= 1'b1;
              end
              default: begin
                oe_q      <= 1'b0;
                tr_q      <= 1'b0;
                bytes_q   <= rx_bytes;
                state     <= S_HUNT;
                rem       <= RW'(TIMEOUT_CLKS);
                rword_q   <= '0;
                rbits_q   <= '0;
                allones_q <= 1'b1;
                clk_q     <= 1'b0;
                low_q     <= 1'b1;
              end
            endcase
          end
        end
        S_TX: if (per_end) begin
          if (idx == '0) begin
            if (echo_q == '0) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= S_ZERO;
              rem   <= RW'(echo_q);
              clk_q <= 1'b0;
              low_q <= 1'b1;
              do_q  <= 1'b1;
            end
          end else begin
            idx    <= idx - 1'b1;
            do_q   <= ~word_q[FRAME_W-1];
            word_q <= word_q << 1;
            clk_q  <= 1'b0;
            low_q  <= 1'b1;
          end
        end
        S_ZERO, S_BPOST: if (per_end) begin
          if (rem == RW'(1)) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            rem   <= rem - 1'b1;
            clk_q <= 1'b0;
            low_q <= 1'b1;
            do_q  <= 1'b1;
          end
        end
        S_BPRE: if (per_end) begin
          clk_q <= 1'b0;
          low_q <= 1'b1;
          if (rem == RW'(1)) begin
            state <= S_BLOW;
            rem   <= RW'(BRK_CLKS);
            do_q  <= 1'b0;
          end else begin
            rem  <= rem - 1'b1;
            do_q <= 1'b1;
          end
        end
        S_BLOW: if (per_end) begin
          clk_q <= 1'b0;
          low_q <= 1'b1;
          if (rem == RW'(1)) begin
            do_q <= 1'b1;
            if (echo_q != '0) begin
              state <= S_BECHO;
              rem   <= RW'(echo_q);
            end else begin
              state <= S_BPOST;
              rem   <= RW'(POST_BRK);
            end
          end else begin
            rem  <= rem - 1'b1;
            do_q <= 1'b0;
          end
        end
        S_BECHO: if (per_end) begin
          clk_q <= 1'b0;
          low_q <= 1'b1;
          do_q  <= 1'b1;
          if (rem == RW'(1)) begin
            state <= S_BPOST;
            rem   <= RW'(POST_BRK);
          end else begin
            rem <= rem - 1'b1;
          end
        end
        S_HUNT: if (per_end) begin
          if (samp_q) begin
            state <= S_HDR;
            rem   <= RW'(HDR_BITS);
            clk_q <= 1'b0;
            low_q <= 1'b1;
          end else if (rem == RW'(1)) begin
            state   <= S_IDLE;
            done_q  <= 1'b1;
            rstat_q <= RS_TIMEOUT;
          end else begin
            rem   <= rem - 1'b1;
            clk_q <= 1'b0;
            low_q <= 1'b1;
          end
        end
        S_HDR: if (per_end) begin
          clk_q <= 1'b0;
          low_q <= 1'b1;
          if (rem == RW'(1)) begin
            if (rword_q[1:0] == TAG_ACK && bytes_q != '0) begin
              state <= S_DATA;
              rem   <= RW'({bytes_q, 3'b000});
            end else begin
              state <= S_CHK;
              rem   <= RW'(CHK_BITS);
            end
          end else begin
            rem <= rem - 1'b1;
          end
        end
        S_DATA: if (per_end) begin
          clk_q <= 1'b0;
          low_q <= 1'b1;
          if (rem == RW'(1)) begin
            state <= S_CHK;
            rem   <= RW'(CHK_BITS);
          end else begin
            rem <= rem - 1'b1;
          end
        end
        S_CHK: if (per_end) begin
          if (rem == RW'(1)) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            if (chk_rem == 4'h0)  rstat_q <= RS_OK;
            else if (allones_q)   rstat_q <= RS_DEAD;
            else                  rstat_q <= RS_CHECK;
          end else begin
            rem   <= rem - 1'b1;
            clk_q <= 1'b0;
            low_q <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready   = !busy;
  assign op_done     = done_q;
  assign resp_status = rstat_q;
  assign resp_word   = rword_q;
  assign resp_bits   = rbits_q;
  assign lnk_clk     = clk_q;
  assign lnk_do      = do_q;
  assign lnk_oe      = oe_q;
  assign lnk_trans   = tr_q;

  // length of the current low half, for the period check
  logic [LW-1:0] low_len;
  always_ff @(posedge clk) begin
    if (rst || lnk_clk) low_len <= '0;
    else                low_len <= low_len + 1'b1;
  end

  // R3: the low half lasts exactly DIV cycles
  a_r3_low_half: assert property (@(posedge clk) disable iff (rst)
    $rose(lnk_clk) |-> (low_len == LW'(DIV)));
  // R3: data moves only with a falling clock
  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$fell(lnk_clk) |-> $stable(lnk_do));
  // R3: clock rests high when idle
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> lnk_clk);
  // R8: pad enable and translator enable move together
  a_r8_oe_pair: assert property (@(posedge clk) disable iff (rst)
    lnk_oe == lnk_trans);
  // R8: the pad is released whenever a frame is being received
  a_r8_rx_released: assert property (@(posedge clk) disable iff (rst)
    (state == S_HUNT || shift_st) |-> !lnk_oe);
  // R2: completion is reported only when the block is free again
  a_r2_done_ready: assert property (@(posedge clk) disable iff (rst)
    op_done |-> cmd_ready);
endmodule

// File: tb/alink_xcvr_tb_top.sv
module alink_xcvr_tb_top;
  localparam int FW   = 64;
  localparam int BW   = 7;
  localparam int DIVT = 4;
  localparam int TO   = 40;
  localparam int PRE  = 4;
  localparam int BRK  = 24;
  localparam int POST = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [FW-1:0] tx_word = '0;
  logic [BW-1:0] tx_bits = '0;
  logic [7:0]    zero_count = '0;
  logic [7:0]    echo_count = '0;
  logic [2:0]    rx_bytes = '0;
  logic          op_done;
  logic [1:0]    resp_status;
  logic [FW-1:0] resp_word;
  logic [BW-1:0] resp_bits;
  logic          lnk_clk, lnk_do, lnk_oe, lnk_trans;
  logic          lnk_di = 1'b1;

  always #10 clk = ~clk;

  alink_xcvr #(.FRAME_W(FW), .DIV(DIVT), .TIMEOUT_CLKS(TO), .PRE_BRK(PRE),
               .BRK_CLKS(BRK), .POST_BRK(POST)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .tx_word(tx_word), .tx_bits(tx_bits),
    .zero_count(zero_count), .echo_count(echo_count), .rx_bytes(rx_bytes),
    .op_done(op_done), .resp_status(resp_status), .resp_word(resp_word),
    .resp_bits(resp_bits), .lnk_clk(lnk_clk), .lnk_do(lnk_do),
    .lnk_oe(lnk_oe), .lnk_trans(lnk_trans), .lnk_di(lnk_di)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
  end

  // pin monitor: one entry per link period, taken at the rising clock
  logic mon_on = 1'b0;
  int   mon_n = 0;
  logic mon_do [0:511];
  logic mon_oe [0:511];
  always @(posedge lnk_clk) begin
    if (mon_on && mon_n < 512) begin
      mon_do[mon_n] = lnk_do;
      mon_oe[mon_n] = lnk_oe;
      mon_n++;
    end
  end

  logic exp_do [0:511];
  int   exp_n;

  function automatic logic [3:0] chk_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
  endfunction

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    mon_n  = 0;
    mon_on = 1'b1;
    cmd_op = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!op_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    mon_on = 1'b0;
  endtask

  task automatic cmp_trace(input string req, input logic oe_exp);
    int bad;
    bad = 0;
    check({req, " periods"}, 64'(mon_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < mon_n; i++) begin
      if (oe_exp && mon_do[i] !== exp_do[i]) bad++;
      if (mon_oe[i] !== oe_exp) bad++;
    end
    check({req, " pin trace mismatches"}, 64'(bad), 64'd0);
  endtask

  task automatic do_send(input string req, input logic [63:0] w, input int nb,
                         input int ec, input bit poke);
    int el;
    exp_n = 0;
    if (nb > 0) begin
      exp_do[exp_n++] = 1'b0;
      for (int i = nb - 1; i >= 0; i--) exp_do[exp_n++] = ~w[i];
      for (int i = 0; i < ec; i++) exp_do[exp_n++] = 1'b1;
    end
    tx_word = w;
    tx_bits = BW'(nb);
    echo_count = 8'(ec);
    issue(2'd0);
    if (poke) begin
      cmd_op = 2'd2;
      zero_count = 8'd5;
      cmd_valid = 1'b1;
      repeat (6) @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_done(el);
    cmp_trace(req, 1'b1);
    if (!poke) check({req, " cycles to done"}, 64'(el), 64'(2 * DIVT * exp_n));
  endtask

  task automatic do_zeros(input string req, input int n);
    int el;
    exp_n = 0;
    for (int i = 0; i < n; i++) exp_do[exp_n++] = 1'b1;
    zero_count = 8'(n);
    issue(2'd2);
    wait_done(el);
    cmp_trace(req, 1'b1);
    check({req, " cycles to done"}, 64'(el), 64'(2 * DIVT * exp_n));
  endtask

  task automatic do_break(input string req, input int ec);
    int el;
    exp_n = 0;
    for (int i = 0; i < PRE; i++)  exp_do[exp_n++] = 1'b1;
    for (int i = 0; i < BRK; i++)  exp_do[exp_n++] = 1'b0;
    for (int i = 0; i < ec; i++)   exp_do[exp_n++] = 1'b1;
    for (int i = 0; i < POST; i++) exp_do[exp_n++] = 1'b1;
    echo_count = 8'(ec);
    issue(2'd3);
    wait_done(el);
    cmp_trace(req, 1'b1);
    check({req, " cycles to done"}, 64'(el), 64'(2 * DIVT * exp_n));
  endtask

  // far-end response model
  logic          wq [0:127];
  int            wlen;
  logic [63:0]   e_word;
  int            e_bits;
  logic [1:0]    e_stat;

  task automatic finish_expect(input logic [63:0] lw, input int lb);
    logic [3:0] c;
    logic       ones;
    c = chk_step(4'h0, 1'b1);
    ones = 1'b1;
    for (int i = lb - 1; i >= 0; i--) begin
      c = chk_step(c, lw[i]);
      ones = ones & lw[i];
    end
    e_word = lw;
    e_bits = lb;
    e_stat = (c == 4'h0) ? 2'd0 : (ones ? 2'd3 : 2'd2);
  endtask

  task automatic build_resp(input logic [1:0] id, input logic [1:0] tag, input int nby,
                            input logic [55:0] data, input int flip, input int dly);
    logic [63:0] lw;
    int          lb;
    logic [3:0]  c;
    lw = '0;
    lb = 0;
    lw = {lw[61:0], id};  lb += 2;
    lw = {lw[61:0], tag}; lb += 2;
    if (tag == 2'b00) begin
      for (int i = nby * 8 - 1; i >= 0; i--) begin
        lw = {lw[62:0], data[i]};
        lb++;
      end
    end
    c = chk_step(4'h0, 1'b1);
    for (int i = lb - 1; i >= 0; i--) c = chk_step(c, lw[i]);
    lw = {lw[59:0], c};
    lb += 4;
    if (flip >= 0) lw[flip] = ~lw[flip];
    wlen = 0;
    for (int i = 0; i < dly; i++) wq[wlen++] = 1'b1;
    wq[wlen++] = 1'b0;
    for (int i = lb - 1; i >= 0; i--) wq[wlen++] = ~lw[i];
    finish_expect(lw, lb);
  endtask

  task automatic do_recv(input string req, input int nby);
    int el;
    rx_bytes = 3'(nby);
    lnk_di = wq[0];
    issue(2'd1);
    for (int k = 1; k < wlen; k++) begin
      @(posedge lnk_clk);
      #5 lnk_di = wq[k];
    end
    @(posedge lnk_clk);
    #5 lnk_di = 1'b1;
    wait_done(el);
    exp_n = wlen;
    cmp_trace(req, 1'b0);
    check({req, " status"}, 64'(resp_status), 64'(e_stat));
    check({req, " bit count"}, 64'(resp_bits), 64'(e_bits));
    check({req, " word"}, resp_word, e_word);
  endtask

  initial begin
    int el;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    check("R1 op_done", 64'(op_done), 64'd0);
    check("R1 lnk_clk", 64'(lnk_clk), 64'd1);
    check("R1 lnk_do", 64'(lnk_do), 64'd1);
    check("R1 oe/trans", 64'({lnk_oe, lnk_trans}), 64'd3);
    check("R1 resp", 64'({resp_status, resp_bits}), 64'd0);
    check("R1 resp_word", resp_word, 64'd0);

    // R4 R5 R3: directed send frame with echo
    do_send("R4 send 12b echo3", 64'h5A3, 12, 3, 1'b0);
    // R2: command presented while busy must not change the trace
    do_send("R2 busy command ignored", 64'h3C, 8, 2, 1'b1);
    // R5: zero echo, and zero bits
    do_send("R5 send echo0", 64'h1, 5, 0, 1'b0);
    do_send("R5 send 0 bits", 64'hFF, 0, 4, 1'b0);
    // R4: random frames, including full width
    do_send("R4 send full width", {$urandom, $urandom}, 64, 1, 1'b0);
    for (int t = 0; t < 6; t++) begin
      do_send("R4 send random", {$urandom, $urandom}, 1 + ($urandom % 64), $urandom % 6, 1'b0);
    end
    // R6 idle clocks
    do_zeros("R6 zeros 5", 5);
    do_zeros("R6 zeros 0", 0);
    // R7 break
    do_break("R7 break echo2", 2);
    do_break("R7 break echo0", 0);

    // R9 timeout: line never starts
    rx_bytes = 3'd2;
    lnk_di = 1'b1;
    issue(2'd1);
    wait_done(el);
    exp_n = TO;
    cmp_trace("R9 timeout", 1'b0);
    check("R9 timeout status", 64'(resp_status), 64'd1);
    check("R9 timeout bits", 64'(resp_bits), 64'd0);
    check("R9 timeout cycles", 64'(el), 64'(2 * DIVT * TO));
    // R8: pad stays released after receive, then a drive op reclaims it
    check("R8 released after rx", 64'({lnk_oe, lnk_trans}), 64'd0);
    do_zeros("R8 zeros after rx", 2);
    check("R8 driven after zeros", 64'({lnk_oe, lnk_trans}), 64'd3);

    // R9 start bit in the last allowed hunt period
    build_resp(2'd1, 2'b00, 1, 56'hA5, -1, TO - 1);
    do_recv("R9 late start", 1);
    // R10 R11 ack with four data bytes
    build_resp(2'd2, 2'b00, 4, 56'hDEADBEEF, -1, 3);
    do_recv("R10 ack 4 bytes", 4);
    // R10 non-ack tag carries no data
    build_resp(2'd3, 2'b01, 2, 56'h1234, -1, 0);
    do_recv("R10 busy tag no data", 2);
    // R10 ack with zero bytes expected
    build_resp(2'd0, 2'b00, 0, 56'h0, -1, 2);
    do_recv("R10 ack no data", 0);
    // R11 corrupted check bit
    build_resp(2'd1, 2'b00, 2, 56'hBEEF, 1, 1);
    do_recv("R11 check error", 2);
    // R12 pin held low after start
    wlen = 0;
    for (int i = 0; i < 4; i++) wq[wlen++] = 1'b1;
    for (int i = 0; i < 9; i++) wq[wlen++] = 1'b0;
    finish_expect(64'hFF, 8);
    do_recv("R12 link dead", 3);
    check("R12 dead status code", 64'(resp_status), 64'd3);
    // R10 R11 R12 random responses
    for (int t = 0; t < 20; t++) begin
      logic [1:0] tg;
      int         nb, fl, lbits;
      tg = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      nb = $urandom % 8;
      lbits = 8 + ((tg == 2'b00) ? nb * 8 : 0);
      fl = (($urandom % 4) == 0) ? int'($urandom % lbits) : -1;
      build_resp(2'($urandom), tg, nb, {$urandom, $urandom}, fl, $urandom % 10);
      do_recv("R11 random response", nb);
    end

    summary();
  end
endmodule